// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block sits beside the command path of a controller for a mobile double-data-rate DRAM. It holds the mode settings: burst length, wrap order and read latency. It takes them from the 13-bit value that goes with a mode-register load. When a READ or WRITE is issued, it produces the column address for every beat of that burst. It raises a flag on the final beat and, for reads, a strobe that marks the cycles in which data returns from the memory.

A load that carries an undefined burst-length or latency code is refused as a whole. The block raises a flag and keeps the settings it had before. A burst latches the length and order that are in force when it starts. A new start strobe cuts off a running burst, and the new burst's first beat appears on the next cycle.

Top module: `ddr_burst_seq`

## Requirements
- R1: After reset the settings are burst length 4, sequential order and read latency 3, the illegal flag is low, no burst is active and the column output is zero.
- R2: Load-value bits [2:0] select the burst length: 3'b001 gives 2 beats, 3'b010 gives 4, 3'b011 gives 8 and 3'b100 gives 16.
- R3: Load-value bit 3 selects the order: 0 is sequential, in which the low log2(BL) column bits count up modulo BL from the start column.
- R4: Value 1 in bit 3 selects interleaved order, in which the low log2(BL) bits of beat k are the start column's low bits XOR k. In both orders the column bits above the low log2(BL) bits stay those of the start column.
- R5: Load-value bits [6:4] select the read latency: 3'b010 gives 2 and 3'b011 gives 3. For a READ, the data-valid strobe is high for BL consecutive cycles, starting CL cycles after the cycle in which the start strobe is high.
- R6: A load whose length code or latency code is anything else sets the illegal flag and leaves all settings unchanged. A later legal load clears the flag, one cycle after the load.
- R7: In the cycle after the start strobe the column output equals the start column and the busy flag is high. Busy stays high for exactly BL cycles, and the column output is zero whenever busy is low.
- R8: The last-beat flag is high only during the final beat of a burst.
- R9: A WRITE burst produces its addresses but never raises the data-valid strobe.
- R10: A start strobe during a running burst ends that burst; the new burst's first beat shows the new start column in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrs_load | input | 1 | Mode-register load strobe |
| mrs_value | input | 13 | Mode value sampled with the load strobe |
| burst_go | input | 1 | Burst start strobe (READ or WRITE command) |
| burst_col | input | 10 | Starting column of the burst |
| burst_is_read | input | 1 | 1 for READ, 0 for WRITE |
| col_addr | output | 10 | Column address of the current beat, zero when idle |
| burst_busy | output | 1 | A burst is producing beats |
| burst_last | output | 1 | Current beat is the final one |
| rd_valid | output | 1 | Read data valid, latency-delayed per beat |
| mode_illegal | output | 1 | Last load carried a reserved code |

## Verification
The hardest case to reach is a restart while a burst is running, because the old burst's expected beats must be dropped at exactly the cycle the new strobe lands. The driver starts an eight-beat WRITE and waits a few cycles. It then strips every expected entry later than that cycle from the scoreboard queue and launches a READ, whose beats and delayed valid strobe must follow without a gap. Reserved codes are made to follow a non-default legal setting. A burst issued afterwards then shows whether the refused load left length, order and latency intact.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } burst_ord_e;

   typedef struct packed {
      logic [2:0] bl_log;   // log2 of the burst length
      burst_ord_e ord;
      logic [2:0] cl;       // read latency in cycles
   } mode_cfg_t;

   localparam mode_cfg_t MODE_AT_RESET = '{bl_log: 3'd2, ord: ORD_SEQ, cl: 3'd3};

   // length code equals log2 of the length for every defined code
   function automatic logic len_code_ok(input logic [2:0] code, input int max_log);
      return (code != 3'd0) && (int'(code) <= 4) && (int'(code) <= max_log);
   endfunction

   function automatic logic lat_code_ok(input logic [2:0] code, input int max_cl);
      return ((code == 3'd2) || (code == 3'd3)) && (int'(code) <= max_cl);
   endfunction

endpackage

// File: rtl/ddr_mode_store.sv
module ddr_mode_store
   import ddr_burst_pkg::*;
#(
   parameter int MR_W     = 13,
   parameter int BL_LOG_M = 4,
   parameter int CL_MAX   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [MR_W-1:0] value,
   output mode_cfg_t       cfg,
   output logic            illegal
);

   logic [2:0] len_code;
   logic       ord_bit;
   logic [2:0] lat_code;
   logic       accept;
   logic       unused_hi;

   assign len_code  = value[2:0];
   assign ord_bit   = value[3];
   assign lat_code  = value[6:4];
   assign unused_hi = ^value[MR_W-1:7];

   assign accept = len_code_ok(len_code, BL_LOG_M) && lat_code_ok(lat_code, CL_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= MODE_AT_RESET;
         illegal <= 1'b0;
      end else if (load) begin
         illegal <= !accept;
         if (accept) begin
            cfg.bl_log <= len_code;
            cfg.ord    <= burst_ord_e'(ord_bit);
            cfg.cl     <= lat_code;
         end
      end
   end

endmodule

// File: rtl/ddr_beat_gen.sv
module ddr_beat_gen
   import ddr_burst_pkg::*;
#(
   parameter int COL_W    = 10,
   parameter int BL_LOG_M = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [COL_W-1:0] start_col,
   input  logic             is_read,
   input  mode_cfg_t        cfg,
   output logic [COL_W-1:0] col,
   output logic             busy,
   output logic             last,
   output logic             beat_rd
);

   localparam int BEAT_W = (BL_LOG_M < 1) ? 1 : BL_LOG_M;

   logic              busy_q;
   logic [BEAT_W-1:0] beat_q;
   logic [COL_W-1:0]  start_q;
   logic [2:0]        bl_log_q;
   burst_ord_e        ord_q;
   logic              rd_q;

   logic [BEAT_W-1:0] final_beat;
   logic [COL_W-1:0]  low_mask;
   logic [COL_W-1:0]  beat_ext;
   logic [COL_W-1:0]  seq_low;
   logic [COL_W-1:0]  ilv_low;
   logic [COL_W-1:0]  col_next;

   assign final_beat = BEAT_W'((32'd1 << bl_log_q) - 32'd1);
   assign low_mask   = ~({COL_W{1'b1}} << bl_log_q);
   assign beat_ext   = COL_W'(beat_q);
   assign seq_low    = (start_q + beat_ext) & low_mask;
   assign ilv_low    = (start_q ^ beat_ext) & low_mask;

   always_comb begin
      col_next = start_q & ~low_mask;
      if (ord_q == ORD_ILV) col_next = col_next | ilv_low;
      else                  col_next = col_next | seq_low;
   end

   assign busy    = busy_q;
   assign last    = busy_q && (beat_q == final_beat);
   assign col     = busy_q ? col_next : '0;
   assign beat_rd = busy_q && rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         beat_q   <= '0;
         start_q  <= '0;
         bl_log_q <= 3'd2;
         ord_q    <= ORD_SEQ;
         rd_q     <= 1'b0;
      end else if (go) begin
         busy_q   <= 1'b1;
         beat_q   <= '0;
         start_q  <= start_col;
         bl_log_q <= cfg.bl_log;
         ord_q    <= cfg.ord;
         rd_q     <= is_read;
      end else if (busy_q) begin
         if (beat_q == final_beat) begin
            busy_q <= 1'b0;
            beat_q <= '0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ddr_rd_delay.sv
module ddr_rd_delay #(
   parameter int CL_MAX = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       beat_rd,
   input  logic [2:0] cl,
   output logic       rd_valid
);

   localparam int DEPTH = CL_MAX - 1;

   logic [DEPTH-1:0] sh_q;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= beat_rd;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[DEPTH-2:0], beat_rd};
         end
      end
   endgenerate

   // stage i holds the beat flag delayed by i+1 cycles; latency L taps stage L-2
   always_comb begin
      rd_valid = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(cl) == i + 2) rd_valid = sh_q[i];
      end
   end

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
   import ddr_burst_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MR_W   = 13,
   parameter int BL_MAX = 16,
   parameter int CL_MAX = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mrs_load,
   input  logic [MR_W-1:0]  mrs_value,
   input  logic             burst_go,
   input  logic [COL_W-1:0] burst_col,
   input  logic             burst_is_read,
   output logic [COL_W-1:0] col_addr,
   output logic             burst_busy,
   output logic             burst_last,
   output logic             rd_valid,
   output logic             mode_illegal
);

   localparam int BL_LOG_M = $clog2(BL_MAX);

   generate
      if (MR_W < 7) begin : g_bad_mr
         $error("mode value must hold at least 7 bits");
      end
      if ((BL_MAX < 4) || (BL_MAX > 16) || ((1 << BL_LOG_M) != BL_MAX)) begin : g_bad_bl
         $error("BL_MAX must be a power of two from 4 to 16");
      end
      if (COL_W < BL_LOG_M + 1) begin : g_bad_col
         $error("COL_W must exceed log2(BL_MAX)");
      end
      if ((CL_MAX < 3) || (CL_MAX > 7)) begin : g_bad_cl
         $error("CL_MAX must lie in 3..7");
      end
   endgenerate

   mode_cfg_t cfg;
   logic      beat_rd;

   ddr_mode_store #(
      .MR_W     (MR_W),
      .BL_LOG_M (BL_LOG_M),
      .CL_MAX   (CL_MAX)
   ) mode_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mrs_load),
      .value   (mrs_value),
      .cfg     (cfg),
      .illegal (mode_illegal)
   );

   ddr_beat_gen #(
      .COL_W    (COL_W),
      .BL_LOG_M (BL_LOG_M)
   ) beat_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (burst_go),
      .start_col (burst_col),
      .is_read   (burst_is_read),
      .cfg       (cfg),
      .col       (col_addr),
      .busy      (burst_busy),
      .last      (burst_last),
      .beat_rd   (beat_rd)
   );

   ddr_rd_delay #(
      .CL_MAX (CL_MAX)
   ) rdly_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .beat_rd  (beat_rd),
      .cl       (cfg.cl),
      .rd_valid (rd_valid)
   );

endmodule

// File: rtl/ddr_burst_seq_chk.sv
module ddr_burst_seq_chk #(
   parameter int COL_W  = 10,
   parameter int MR_W   = 13,
   parameter int BL_MAX = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mrs_load,
   input logic [MR_W-1:0]  mrs_value,
   input logic             burst_go,
   input logic [COL_W-1:0] burst_col,
   input logic [COL_W-1:0] col_addr,
   input logic             burst_busy,
   input logic             burst_last,
   input logic             mode_illegal
);

   localparam int BL_LOG_M = $clog2(BL_MAX);

   logic reserved;
   assign reserved = !((mrs_value[2:0] >= 3'd1) && (int'(mrs_value[2:0]) <= BL_LOG_M))
                  || !((mrs_value[6:4] == 3'd2) || (mrs_value[6:4] == 3'd3));

   AST_RESERVED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_load && reserved |=> mode_illegal); // R6
   AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_load && !reserved |=> !mode_illegal); // R6
   AST_START_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
      burst_go |=> burst_busy && (col_addr == $past(burst_col))); // R7
   AST_IDLE_COL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_busy |-> (col_addr == '0)); // R7
   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      burst_busy && !burst_last && !burst_go |=>
         (col_addr[COL_W-1:BL_LOG_M] == $past(col_addr[COL_W-1:BL_LOG_M]))); // R4
   AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      burst_last |-> burst_busy); // R8
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      burst_last && !burst_go |=> !burst_busy); // R8

endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(
   .COL_W  (COL_W),
   .MR_W   (MR_W),
   .BL_MAX (BL_MAX)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .mrs_load     (mrs_load),
   .mrs_value    (mrs_value),
   .burst_go     (burst_go),
   .burst_col    (burst_col),
   .col_addr     (col_addr),
   .burst_busy   (burst_busy),
   .burst_last   (burst_last),
   .mode_illegal (mode_illegal)
);

// File: tb/ddr_burst_seq_tb_top.sv
module ddr_burst_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int COL_W = 10;
   localparam int MR_W  = 13;

   typedef struct {
      int               cyc;
      logic             busy;
      logic             last;
      logic             rdv;
      logic [COL_W-1:0] col;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mrs_load = 1'b0;
   logic [MR_W-1:0]  mrs_value = '0;
   logic             burst_go = 1'b0;
   logic [COL_W-1:0] burst_col = '0;
   logic             burst_is_read = 1'b0;
   logic [COL_W-1:0] col_addr;
   logic             burst_busy;
   logic             burst_last;
   logic             rd_valid;
   logic             mode_illegal;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_errors = 0;
   exp_t sb[$];

   // settings as the bench believes them to be
   int m_bl = 4;
   int m_ilv = 0;
   int m_cl = 3;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ddr_burst_seq dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .mrs_load      (mrs_load),
      .mrs_value     (mrs_value),
      .burst_go      (burst_go),
      .burst_col     (burst_col),
      .burst_is_read (burst_is_read),
      .col_addr      (col_addr),
      .burst_busy    (burst_busy),
      .burst_last    (burst_last),
      .rd_valid      (rd_valid),
      .mode_illegal  (mode_illegal)
   );

   function automatic logic [COL_W-1:0] want_col(logic [COL_W-1:0] s, int k, int bl, int ilv);
      logic [COL_W-1:0] mask;
      logic [COL_W-1:0] low;
      mask = COL_W'(bl - 1);
      low  = (ilv != 0) ? ((s ^ COL_W'(k)) & mask) : ((s + COL_W'(k)) & mask);
      return (s & ~mask) | low;
   endfunction

   task automatic check1(string tag, logic ok, string what);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: %s", tag, what);
      end
   endtask

   // monitor: pops expected items as their cycle comes up
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         if (e.cyc == cyc) begin
            check1(e.tag,
                   (burst_busy === e.busy) && (burst_last === e.last) &&
                   (rd_valid === e.rdv) && (col_addr === e.col),
                   $sformatf("cyc %0d actual busy=%b last=%b rdv=%b col=%h expected busy=%b last=%b rdv=%b col=%h",
                             cyc, burst_busy, burst_last, rd_valid, col_addr,
                             e.busy, e.last, e.rdv, e.col));
         end
      end
   end

   // driver: called at a negedge; strobe is seen at the next rising edge
   task automatic start_burst(logic [COL_W-1:0] s, logic rd, string tag);
      int n;
      n = cyc;
      burst_go      = 1'b1;
      burst_col     = s;
      burst_is_read = rd;
      for (int c = n + 1; c <= n + m_bl + m_cl; c++) begin
         exp_t e;
         int k;
         k = c - n - 1;
         e.cyc  = c;
         e.busy = (k < m_bl);
         e.last = (k == m_bl - 1);
         e.col  = (k < m_bl) ? want_col(s, k, m_bl, m_ilv) : '0;
         e.rdv  = rd && (c >= n + m_cl) && (c < n + m_cl + m_bl);
         e.tag  = tag;
         sb.push_back(e);
      end
      @(negedge clk);
      burst_go = 1'b0;
   endtask

   task automatic drain();
      repeat (m_bl + m_cl + 2) @(negedge clk);
   endtask

   task automatic load_mode(int bl_code, int ilv, int cl_code, string tag);
      logic legal;
      mrs_value = MR_W'({cl_code[2:0], ilv[0], bl_code[2:0]});
      mrs_load  = 1'b1;
      @(negedge clk);
      mrs_load  = 1'b0;
      legal = (bl_code >= 1 && bl_code <= 4) && (cl_code == 2 || cl_code == 3);
      if (legal) begin
         m_bl  = 1 << bl_code;
         m_ilv = ilv;
         m_cl  = cl_code;
      end
      check1(tag, mode_illegal === !legal,
             $sformatf("illegal flag actual %b expected %b", mode_illegal, !legal));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check1("R1", (burst_busy === 1'b0) && (col_addr === '0) && (rd_valid === 1'b0) &&
                   (mode_illegal === 1'b0) && (burst_last === 1'b0),
             $sformatf("reset outputs actual busy=%b col=%h rdv=%b ill=%b expected 0 0 0 0",
                       burst_busy, col_addr, rd_valid, mode_illegal));
      // R1: default BL4 sequential CL3
      start_burst(10'h3A6, 1'b1, "R1");
      drain();

      // R2/R3: every length, sequential
      load_mode(1, 0, 3, "R2");
      start_burst(10'h055, 1'b1, "R2");
      drain();
      load_mode(3, 0, 3, "R3");
      start_burst(10'h1FD, 1'b1, "R3");
      drain();
      load_mode(4, 0, 2, "R2");
      start_burst(10'h2A9, 1'b1, "R2");
      drain();

      // R4: interleaved order
      load_mode(3, 1, 3, "R4");
      start_burst(10'h10D, 1'b1, "R4");
      drain();
      load_mode(4, 1, 2, "R4");
      start_burst(10'h3F6, 1'b1, "R4");
      drain();
      load_mode(2, 1, 2, "R4");
      start_burst(10'h003, 1'b0, "R4");
      drain();

      // R5: latency 2 then 3
      load_mode(2, 0, 2, "R5");
      start_burst(10'h0F2, 1'b1, "R5");
      drain();
      load_mode(1, 0, 3, "R5");
      start_burst(10'h201, 1'b1, "R5");
      drain();

      // R9: write bursts give no data-valid
      load_mode(3, 0, 2, "R9");
      start_burst(10'h14E, 1'b0, "R9");
      drain();

      // R6: reserved codes refused, settings kept (BL8 seq CL2)
      load_mode(0, 1, 3, "R6");
      load_mode(5, 1, 3, "R6");
      load_mode(7, 0, 2, "R6");
      load_mode(2, 1, 0, "R6");
      load_mode(2, 1, 1, "R6");
      load_mode(4, 1, 4, "R6");
      start_burst(10'h0A3, 1'b1, "R6");
      drain();
      load_mode(1, 1, 3, "R6");
      start_burst(10'h0A3, 1'b1, "R6");
      drain();

      // R10: restart during a running write
      load_mode(3, 0, 3, "R10");
      start_burst(10'h2C4, 1'b0, "R10");
      repeat (2) @(negedge clk);
      begin
         exp_t keep[$];
         int cut;
         cut = cyc;
         foreach (sb[i]) if (sb[i].cyc <= cut) keep.push_back(sb[i]);
         sb = keep;
      end
      start_burst(10'h11B, 1'b1, "R10");
      drain();

      // R8: last-beat on 16-beat sequential burst crossing wrap
      load_mode(4, 0, 3, "R8");
      start_burst(10'h37B, 1'b1, "R8");
      drain();

      check1("R7", sb.size() == 0,
             $sformatf("scoreboard leftover actual %0d expected 0", sb.size()));
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule